// File: doc/BRIEF.md
# Transactional Cache with Overflow Spill

This block is a set-associative data cache that keeps the speculative state of one hardware transaction. A load or store issued inside a transaction marks the line it touches as transactional. A store of that kind updates only the cached copy. Main memory therefore keeps the value that an abort restores, and the cache keeps the value that a commit publishes. Stores made outside a transaction are written through to memory, so a line that carries no transactional mark always matches memory.

Sometimes a transactional line has to give up its way to a new line. The displaced line is then moved into a small internal overflow store, and its set is flagged as having spilled. Any later miss in a flagged set looks in the overflow store before it goes to memory. If the line is found there, it is exchanged with the set's replacement victim and the access completes as a hit. A commit is a multi-cycle sweep that copies every marked line and every overflow entry to memory, then drops all marks. While the commit sweep runs, incoming coherence interventions are refused. An abort is a sweep of the same length that invalidates every marked line, empties the overflow store and drops all marks.

Top module: `txc_cache`

## Requirements
- R1: An accepted request (`req_valid` high while `busy` is low) gets its response exactly one cycle later with `rsp_valid` high. A load returns the current value of the line. A store echoes its write data on `rsp_rdata`.
- R2: A transactional access marks its line. A non-transactional access leaves the mark as it was. A non-transactional access whose line is marked, whether the line is found in the cache or brought back from overflow, raises `rsp_conflict`.
- R3: A line address maps to set `addr % SETS`. A fill goes into the lowest-numbered invalid way of that set. If no way is invalid, the fill goes into the least recently used way. Every completed access makes its way the most recently used.
- R4: When a marked line is displaced, it is written into the overflow store and its set's spill flag is set. The response shows `rsp_spill` high.
- R5: A miss in a set whose spill flag is set searches the overflow store. If the line is found, it is swapped into the victim way, and `rsp_hit` and `rsp_ovf_hit` are both high. If that victim is marked, it takes over the freed overflow slot and `rsp_spill` is high.
- R6: A miss in a set whose spill flag is clear never reports `rsp_ovf_hit`.
- R7: A fill whose victim is marked while the overflow store is full reports `rsp_fault`, with `rsp_hit`, `rsp_spill` and `rsp_rdata` all zero. The cache, the overflow store and memory stay unchanged.
- R8: A non-transactional store writes memory in the cycle it is accepted, and does not allocate a line on a miss. A transactional store never writes memory before a commit.
- R9: A commit writes every marked line and every overflow entry to memory, then clears all marks and spill flags. While the commit sweep runs, `snoop_nack` follows `snoop_valid`.
- R10: An abort invalidates every marked line, empties the overflow store and clears all spill flags, and it leaves memory unchanged. `snoop_nack` stays low throughout the abort.
- R11: A commit or abort keeps `busy` high for exactly `SETS*WAYS + OVF_DEPTH` cycles. No request made while `busy` is high produces a response or changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_tx | input | 1 | Access belongs to the running transaction |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Store data |
| xact_commit | input | 1 | Start a commit sweep (takes priority over abort) |
| xact_abort | input | 1 | Start an abort sweep |
| busy | output | 1 | Sweep in progress; requests ignored |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Line found in the cache or the overflow store |
| rsp_ovf_hit | output | 1 | Line found in the overflow store |
| rsp_conflict | output | 1 | Non-transactional access to a marked line |
| rsp_spill | output | 1 | A marked victim moved to the overflow store |
| rsp_fault | output | 1 | Overflow store full; access dropped |
| rsp_rdata | output | DATA_W | Load data, or echoed store data |
| mem_addr | output | ADDR_W | Memory line address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, combinational from mem_addr |
| snoop_valid | input | 1 | Incoming coherence intervention |
| snoop_nack | output | 1 | Intervention refused during a commit |

## Verification
The assertions rely on three things about the inputs. Memory answers `mem_rdata` combinationally in the cycle that `mem_addr` is driven. Reset is held for at least one clock edge. Nothing but this block writes memory while a transaction is open. The bench respects all three. It models memory as an array that only the block's `mem_we` writes, and it holds reset for several cycles. It issues commits and aborts only while the block is idle, except in one deliberate test that sends requests during a sweep. Random addresses come from a narrow pool so that sets fill, spill and hit the full-store fault.

// File: rtl/txc_pkg.sv
`timescale 1ns/1ps
package txc_pkg;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_COMMIT = 2'd1,
        SW_ABORT  = 2'd2
    } sweep_mode_e;

    typedef enum logic [1:0] {
        PATH_HIT    = 2'd0,
        PATH_SWAP   = 2'd1,
        PATH_FILL   = 2'd2,
        PATH_BYPASS = 2'd3
    } acc_path_e;

    // Start slot for the linear probe of the overflow store.
    function automatic int unsigned ovf_hash(input logic [31:0] line_addr);
        return int'(line_addr ^ (line_addr >> 3));
    endfunction

endpackage

// File: rtl/txc_sweep.sv
`timescale 1ns/1ps
module txc_sweep
    import txc_pkg::*;
#(
    parameter int STEPS = 12,
    localparam int IW = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_commit,
    input  logic          start_abort,
    output logic          busy,
    output sweep_mode_e   mode,
    output logic [IW-1:0] idx,
    output logic          last
);

    assign busy = (mode != SW_IDLE);
    assign last = busy && (idx == IW'(STEPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= SW_IDLE;
            idx  <= '0;
        end else if (mode == SW_IDLE) begin
            idx <= '0;
            if (start_commit)     mode <= SW_COMMIT;
            else if (start_abort) mode <= SW_ABORT;
        end else if (last) begin
            mode <= SW_IDLE;
            idx  <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end

    AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy); // R11
    AST_SWEEP_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(busy)) |-> (idx == '0)); // R11

endmodule

// File: rtl/txc_ovf_store.sv
`timescale 1ns/1ps
module txc_ovf_store
    import txc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int OW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [OW-1:0]     look_idx,
    output logic [DATA_W-1:0] look_data,
    input  logic [ADDR_W-1:0] ins_addr,
    output logic              free_ok,
    output logic [OW-1:0]     free_idx,
    input  logic              wr_en,
    input  logic [OW-1:0]     wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              kill_en,
    input  logic [OW-1:0]     kill_idx,
    input  logic [OW-1:0]     rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic              slot_v [DEPTH];
    logic [ADDR_W-1:0] slot_a [DEPTH];
    logic [DATA_W-1:0] slot_d [DEPTH];
    int unsigned       probe_base;

    assign probe_base = ovf_hash(32'(ins_addr)) % DEPTH;

    // Lookup compares every slot at once.
    always_comb begin
        look_hit  = 1'b0;
        look_idx  = '0;
        look_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!look_hit && slot_v[i] && slot_a[i] == look_addr) begin
                look_hit  = 1'b1;
                look_idx  = OW'(i);
                look_data = slot_d[i];
            end
        end
    end

    // Insertion takes the first free slot, probing linearly from the hash.
    always_comb begin
        logic [OW-1:0] cand;
        cand     = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int p = 0; p < DEPTH; p++) begin
            cand = OW'((probe_base + p) % DEPTH);
            if (!free_ok && !slot_v[cand]) begin
                free_ok  = 1'b1;
                free_idx = cand;
            end
        end
    end

    assign rd_valid = slot_v[rd_idx];
    assign rd_addr  = slot_a[rd_idx];
    assign rd_data  = slot_d[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_v[i] <= 1'b0;
        end else begin
            if (kill_en) slot_v[kill_idx] <= 1'b0;
            if (wr_en) begin
                slot_v[wr_idx] <= 1'b1;
                slot_a[wr_idx] <= wr_addr;
                slot_d[wr_idx] <= wr_data;
            end
        end
    end

    AST_SLOT_NOT_CLOBBERED: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (!slot_v[wr_idx] || (kill_en && kill_idx == wr_idx))); // R4
    AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(kill_en && kill_idx == wr_idx)) |-> !(look_hit && look_addr == wr_addr)); // R5

endmodule

// File: rtl/txc_cache.sv
`timescale 1ns/1ps
module txc_cache
    import txc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int SETS      = 4,
    parameter int WAYS      = 2,
    parameter int OVF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_tx,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              xact_commit,
    input  logic              xact_abort,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_ovf_hit,
    output logic              rsp_conflict,
    output logic              rsp_spill,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snoop_valid,
    output logic              snoop_nack
);

    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINES  = SETS * WAYS;
    localparam int OVF_W  = $clog2(OVF_DEPTH);
    localparam int STEPS  = LINES + OVF_DEPTH;
    localparam int STEP_W = $clog2(STEPS);

    // Line state
    logic              line_v   [SETS][WAYS];
    logic              line_t   [SETS][WAYS];
    logic [TAG_W-1:0]  line_tag [SETS][WAYS];
    logic [DATA_W-1:0] line_d   [SETS][WAYS];
    logic [WAY_W-1:0]  line_age [SETS][WAYS];
    logic              set_o    [SETS];

    // Sweep engine
    sweep_mode_e       sw_mode;
    logic [STEP_W-1:0] sw_idx;
    logic              sw_last;
    logic              sw_is_line;
    logic [IDX_W-1:0]  sw_set;
    logic [WAY_W-1:0]  sw_way;
    logic [OVF_W-1:0]  sw_slot;

    txc_sweep #(.STEPS(STEPS)) u_sweep (
        .clk(clk), .rst(rst),
        .start_commit(xact_commit), .start_abort(xact_abort),
        .busy(busy), .mode(sw_mode), .idx(sw_idx), .last(sw_last)
    );

    assign sw_is_line = (sw_idx < STEP_W'(LINES));
    assign sw_set     = IDX_W'(int'(sw_idx) / WAYS);
    assign sw_way     = WAY_W'(int'(sw_idx) % WAYS);
    assign sw_slot    = OVF_W'(int'(sw_idx) - LINES);

    // Request decode
    logic              acc;
    logic [IDX_W-1:0]  set_i;
    logic [TAG_W-1:0]  tag_i;
    logic              hit;
    logic [WAY_W-1:0]  hit_w, vict_w, way_sel;
    logic              have_inv;
    acc_path_e         path;
    logic              victim_t, fault, spill, old_t, upd_line;
    logic [ADDR_W-1:0] victim_addr;
    logic [DATA_W-1:0] base_data, new_data;

    logic              ov_look_hit, ov_free_ok, ov_wr_en, ov_kill_en, ov_rd_valid;
    logic [OVF_W-1:0]  ov_look_idx, ov_free_idx, ov_wr_idx, ov_kill_idx;
    logic [DATA_W-1:0] ov_look_data, ov_rd_data;
    logic [ADDR_W-1:0] ov_rd_addr;

    assign acc   = req_valid && !busy;
    assign set_i = req_addr[IDX_W-1:0];
    assign tag_i = req_addr[ADDR_W-1:IDX_W];

    always_comb begin
        hit      = 1'b0;
        hit_w    = '0;
        have_inv = 1'b0;
        vict_w   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (line_v[set_i][w] && line_tag[set_i][w] == tag_i) begin
                hit   = 1'b1;
                hit_w = WAY_W'(w);
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!line_v[set_i][w]) begin
                have_inv = 1'b1;
                vict_w   = WAY_W'(w);
            end
        end
        if (!have_inv) begin
            for (int w = 0; w < WAYS; w++) begin
                if (line_age[set_i][w] == WAY_W'(WAYS - 1)) vict_w = WAY_W'(w);
            end
        end
    end

    assign victim_t    = line_v[set_i][vict_w] && line_t[set_i][vict_w];
    assign victim_addr = {line_tag[set_i][vict_w], set_i};

    always_comb begin
        if (hit)                               path = PATH_HIT;
        else if (set_o[set_i] && ov_look_hit)  path = PATH_SWAP;
        else if (req_write && !req_tx)         path = PATH_BYPASS;
        else                                   path = PATH_FILL;
    end

    assign way_sel  = (path == PATH_HIT) ? hit_w : vict_w;
    assign fault    = acc && (path == PATH_FILL) && victim_t && !ov_free_ok;
    assign spill    = acc && ((path == PATH_FILL) || (path == PATH_SWAP)) && victim_t && !fault;
    assign upd_line = acc && !fault && (path != PATH_BYPASS);

    always_comb begin
        unique case (path)
            PATH_HIT:  begin base_data = line_d[set_i][hit_w]; old_t = line_t[set_i][hit_w]; end
            PATH_SWAP: begin base_data = ov_look_data;         old_t = 1'b1;                  end
            PATH_FILL: begin base_data = mem_rdata;            old_t = 1'b0;                  end
            default:   begin base_data = '0;                   old_t = 1'b0;                  end
        endcase
    end
    assign new_data = req_write ? req_wdata : base_data;

    // Overflow store control
    assign ov_wr_en    = spill;
    assign ov_wr_idx   = (path == PATH_SWAP) ? ov_look_idx : ov_free_idx;
    assign ov_kill_en  = (acc && path == PATH_SWAP) || (busy && !sw_is_line);
    assign ov_kill_idx = busy ? sw_slot : ov_look_idx;

    txc_ovf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(OVF_DEPTH)) u_ovf (
        .clk(clk), .rst(rst),
        .look_addr(req_addr), .look_hit(ov_look_hit), .look_idx(ov_look_idx), .look_data(ov_look_data),
        .ins_addr(victim_addr), .free_ok(ov_free_ok), .free_idx(ov_free_idx),
        .wr_en(ov_wr_en), .wr_idx(ov_wr_idx), .wr_addr(victim_addr), .wr_data(line_d[set_i][vict_w]),
        .kill_en(ov_kill_en), .kill_idx(ov_kill_idx),
        .rd_idx(sw_slot), .rd_valid(ov_rd_valid), .rd_addr(ov_rd_addr), .rd_data(ov_rd_data)
    );

    // Memory port: sweep write-back or the request's own traffic
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        if (sw_mode == SW_COMMIT) begin
            if (sw_is_line) begin
                mem_we    = line_v[sw_set][sw_way] && line_t[sw_set][sw_way];
                mem_addr  = {line_tag[sw_set][sw_way], sw_set};
                mem_wdata = line_d[sw_set][sw_way];
            end else begin
                mem_we    = ov_rd_valid;
                mem_addr  = ov_rd_addr;
                mem_wdata = ov_rd_data;
            end
        end else if (acc && req_write && !req_tx) begin
            mem_we = 1'b1;
        end
    end

    assign snoop_nack = snoop_valid && (sw_mode == SW_COMMIT);

    logic [IDX_W-1:0] rsp_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                set_o[s] <= 1'b0;
                for (int w = 0; w < WAYS; w++) begin
                    line_v[s][w]   <= 1'b0;
                    line_t[s][w]   <= 1'b0;
                    line_age[s][w] <= WAY_W'(w);
                end
            end
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_ovf_hit  <= 1'b0;
            rsp_conflict <= 1'b0;
            rsp_spill    <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_set      <= '0;
        end else begin
            rsp_valid    <= acc;
            rsp_hit      <= acc && !fault && (path == PATH_HIT || path == PATH_SWAP);
            rsp_ovf_hit  <= acc && (path == PATH_SWAP);
            rsp_conflict <= acc && !fault && !req_tx && old_t;
            rsp_spill    <= spill;
            rsp_fault    <= fault;
            rsp_rdata    <= fault ? '0 : new_data;
            rsp_set      <= set_i;

            if (upd_line) begin
                line_v[set_i][way_sel]   <= 1'b1;
                line_tag[set_i][way_sel] <= tag_i;
                line_d[set_i][way_sel]   <= new_data;
                line_t[set_i][way_sel]   <= old_t || req_tx;
                for (int w = 0; w < WAYS; w++) begin
                    if (line_age[set_i][w] < line_age[set_i][way_sel])
                        line_age[set_i][w] <= line_age[set_i][w] + 1'b1;
                end
                line_age[set_i][way_sel] <= '0;
            end
            if (spill) set_o[set_i] <= 1'b1;

            if (busy && sw_is_line) begin
                line_t[sw_set][sw_way] <= 1'b0;
                if (sw_mode == SW_ABORT && line_t[sw_set][sw_way])
                    line_v[sw_set][sw_way] <= 1'b0;
            end
            if (sw_last) begin
                for (int s = 0; s < SETS; s++) set_o[s] <= 1'b0;
            end
        end
    end

    AST_TX_NO_MEMWR: assert property (@(posedge clk) disable iff (rst)
        (acc && req_tx) |-> !mem_we); // R8
    AST_OVF_HIT_NEEDS_O: assert property (@(posedge clk) disable iff (rst)
        rsp_ovf_hit |-> set_o[rsp_set]); // R6
    AST_NACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        snoop_nack |-> busy); // R9
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (!rsp_spill && !rsp_hit)); // R7
    AST_NO_RSP_IN_SWEEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !rsp_valid); // R11
    AST_ABORT_NO_MEMWR: assert property (@(posedge clk) disable iff (rst)
        (sw_mode == SW_ABORT) |-> !mem_we); // R10

endmodule

// File: tb/tb_txc_cache.sv
`timescale 1ns/1ps
module tb_txc_cache;

    localparam int NS = 4, NW = 2, ND = 4, MEMN = 256;
    localparam int STEPS = NS * NW + ND;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_tx = 0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic xact_commit = 0, xact_abort = 0, snoop_valid = 0;
    logic busy, rsp_valid, rsp_hit, rsp_ovf_hit, rsp_conflict, rsp_spill, rsp_fault, mem_we, snoop_nack;
    logic [15:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [7:0]  mem_addr;

    always #2 clk = ~clk;

    txc_cache dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_tx(req_tx),
        .req_addr(req_addr), .req_wdata(req_wdata), .xact_commit(xact_commit), .xact_abort(xact_abort),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ovf_hit(rsp_ovf_hit),
        .rsp_conflict(rsp_conflict), .rsp_spill(rsp_spill), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .snoop_valid(snoop_valid), .snoop_nack(snoop_nack)
    );

    // Environment memory
    logic [15:0] mem [MEMN];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    // Reference model
    int          m_v [NS][NW], m_t [NS][NW], m_tag [NS][NW], m_age [NS][NW], m_o [NS];
    logic [15:0] m_d [NS][NW];
    int          ov_v [ND], ov_a [ND];
    logic [15:0] ov_d [ND];
    logic [15:0] ref_mem [MEMN];

    int n_chk = 0, n_fail = 0, cyc = 0, faults_seen = 0;
    bit done = 0;

    function automatic logic [15:0] init_val(input int a);
        return 16'((a * 37 + 5) & 16'hffff);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic touch(input int s, input int way);
        int old;
        old = m_age[s][way];
        for (int w = 0; w < NW; w++) if (m_age[s][w] < old) m_age[s][w]++;
        m_age[s][way] = 0;
    endtask

    // One access: model prediction, then drive and compare
    task automatic access(input bit wr, input bit tx, input int addr, input logic [15:0] wd, input string ftag);
        int s, tg, hw, vw, fd, way, free;
        bit e_hit, e_ovf, e_conf, e_spill, e_fault, byp, vt, oldt;
        logic [15:0] base, e_data;
        logic [31:0] expv, actv;
        string tag;
        s = addr % NS; tg = addr / NS; hw = -1; vw = -1; fd = -1; free = -1;
        e_hit = 0; e_ovf = 0; e_conf = 0; e_spill = 0; e_fault = 0; byp = 0; oldt = 0; base = '0; way = 0;
        for (int w = 0; w < NW; w++) if (m_v[s][w] != 0 && m_tag[s][w] == tg) hw = w;
        for (int w = NW - 1; w >= 0; w--) if (m_v[s][w] == 0) vw = w;
        if (vw < 0) for (int w = 0; w < NW; w++) if (m_age[s][w] == NW - 1) vw = w;
        if (hw < 0 && m_o[s] != 0) for (int i = 0; i < ND; i++) if (ov_v[i] != 0 && ov_a[i] == addr) fd = i;
        for (int i = ND - 1; i >= 0; i--) if (ov_v[i] == 0) free = i;
        vt = (m_v[s][vw] != 0) && (m_t[s][vw] != 0);
        if (hw >= 0) begin
            way = hw; base = m_d[s][hw]; oldt = (m_t[s][hw] != 0); e_hit = 1;
        end else if (fd >= 0) begin
            way = vw; base = ov_d[fd]; oldt = 1; e_hit = 1; e_ovf = 1;
            if (vt) begin ov_a[fd] = m_tag[s][vw] * NS + s; ov_d[fd] = m_d[s][vw]; e_spill = 1; end
            else ov_v[fd] = 0;
        end else if (wr && !tx) begin
            byp = 1;
        end else begin
            way = vw; base = ref_mem[addr];
            if (vt) begin
                if (free < 0) e_fault = 1;
                else begin
                    ov_v[free] = 1; ov_a[free] = m_tag[s][vw] * NS + s; ov_d[free] = m_d[s][vw];
                    e_spill = 1; m_o[s] = 1;
                end
            end
        end
        e_data = e_fault ? 16'h0 : (wr ? wd : base);
        e_conf = !e_fault && !tx && oldt;
        if (!e_fault && !byp) begin
            m_v[s][way] = 1; m_tag[s][way] = tg; m_d[s][way] = e_data;
            m_t[s][way] = (oldt || tx) ? 1 : 0;
            touch(s, way);
        end
        if (wr && !tx) ref_mem[addr] = wd;
        if (e_fault) faults_seen++;

        @(negedge clk);
        req_valid = 1; req_write = wr; req_tx = tx; req_addr = 8'(addr); req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        expv = {10'b0, 1'b1, e_hit, e_ovf, e_conf, e_spill, e_fault, e_data};
        actv = {10'b0, rsp_valid, rsp_hit, rsp_ovf_hit, rsp_conflict, rsp_spill, rsp_fault, rsp_rdata};
        if (ftag != "") tag = ftag;
        else if (e_fault) tag = "R7";
        else if (e_ovf) tag = "R5";
        else if (e_spill) tag = "R4";
        else if (e_conf) tag = "R2";
        else tag = "R1";
        chk(tag, $sformatf("access a=%0d wr=%0d tx=%0d {v,hit,ovf,conf,spill,fault,data}", addr, wr, tx), actv, expv);
    endtask

    // Commit or abort sweep; optionally pokes a request while busy
    task automatic sweep(input bit is_commit, input bit poke);
        int n, nack_bad, rsp_seen;
        string tg;
        tg = is_commit ? "R9" : "R10";
        n = 0; nack_bad = 0; rsp_seen = 0;
        @(negedge clk);
        xact_commit = is_commit; xact_abort = !is_commit; snoop_valid = 1;
        @(negedge clk);
        xact_commit = 0; xact_abort = 0;
        if (poke) begin req_valid = 1; req_write = 1; req_tx = 1; req_addr = 8'd200; req_wdata = 16'hdead; end
        while (busy && n < 1000) begin
            if (snoop_nack !== is_commit) nack_bad++;
            if (rsp_valid) rsp_seen++;
            n++;
            @(negedge clk);
        end
        req_valid = 0; snoop_valid = 0;
        chk("R11", "sweep busy cycles", 32'(n), 32'(STEPS));
        chk(tg, "snoop_nack during sweep mismatches", 32'(nack_bad), 32'd0);
        if (poke) chk("R11", "responses while busy", 32'(rsp_seen), 32'd0);
        for (int s = 0; s < NS; s++) begin
            m_o[s] = 0;
            for (int w = 0; w < NW; w++) begin
                if (m_v[s][w] != 0 && m_t[s][w] != 0) begin
                    if (is_commit) ref_mem[m_tag[s][w] * NS + s] = m_d[s][w];
                    else m_v[s][w] = 0;
                end
                m_t[s][w] = 0;
            end
        end
        for (int i = 0; i < ND; i++) begin
            if (is_commit && ov_v[i] != 0) ref_mem[ov_a[i]] = ov_d[i];
            ov_v[i] = 0;
        end
    endtask

    initial begin
        int r, a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMN; i++) begin mem[i] = init_val(i); ref_mem[i] = init_val(i); end
        for (int s = 0; s < NS; s++) begin
            m_o[s] = 0;
            for (int w = 0; w < NW; w++) begin m_v[s][w] = 0; m_t[s][w] = 0; m_tag[s][w] = 0; m_age[s][w] = w; m_d[s][w] = '0; end
        end
        for (int i = 0; i < ND; i++) begin ov_v[i] = 0; ov_a[i] = 0; ov_d[i] = '0; end

        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R11", "reset busy", 32'(busy), 32'd0);
        chk("R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R9", "reset snoop_nack", 32'(snoop_nack), 32'd0);

        // Directed: set 0 fills, spills, swaps
        access(1, 1, 0, 16'h00a0, "R1");
        chk("R8", "memory after tx store", 32'(mem[0]), 32'(init_val(0)));
        access(0, 1, 4, 16'h0, "R3");
        access(0, 1, 0, 16'h0, "R1");
        access(0, 1, 8, 16'h0, "R4");
        access(0, 0, 4, 16'h0, "R5");
        access(0, 0, 1, 16'h0, "R6");
        access(1, 0, 5, 16'h0bee, "R8");
        chk("R8", "memory after plain store", 32'(mem[5]), 32'h0bee);
        for (int k = 3; k < 11; k++) access(0, 1, 4 * k, 16'h0, "");
        chk("R7", "full overflow store produced a fault", 32'(faults_seen > 0), 32'd1);
        sweep(0, 0);
        access(0, 0, 0, 16'h0, "R10");
        chk("R10", "memory keeps rollback value", 32'(mem[0]), 32'(init_val(0)));

        // Directed commit with spilled data
        access(1, 1, 40, 16'h1234, "R1");
        for (int k = 11; k < 14; k++) access(1, 1, 4 * k, 16'(k), "R4");
        sweep(1, 0);
        chk("R9", "committed value reached memory", 32'(mem[40]), 32'h1234);
        chk("R9", "committed overflow value reached memory", 32'(mem[48]), 32'd12);
        access(0, 1, 2, 16'h0, "R2");
        access(0, 0, 2, 16'h0, "R2");
        sweep(0, 1);
        access(0, 0, 200, 16'h0, "R11");

        // Constrained random
        for (int i = 0; i < 1500; i++) begin
            r = int'($urandom % 100);
            a = int'($urandom % 24);
            if (r < 3) sweep(1, 0);
            else if (r < 5) sweep(0, (r == 4));
            else access(1'($urandom % 2), (($urandom % 10) < 7), a, 16'($urandom), "");
        end
        sweep(1, 0);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < MEMN; i++) if (mem[i] !== ref_mem[i]) bad++;
            chk("R9", "memory words differing after final commit", 32'(bad), 32'd0);
        end
        finish_run();
    end

endmodule